// File: doc/BRIEF.md
# Inter-Processor and Interval-Timer Interrupt Unit

This unit holds two small pending vectors with one bit per processor. One vector tracks inter-processor interrupts and the other tracks interval-timer interrupts. Every pending bit drives its own interrupt line to its processor, and that line stays high until software clears the bit.

Software reaches the unit through a simple register port with four slots. A shared control word carries separate post and clear fields for both interrupt classes. Dedicated status slots show each pending vector and clear the bits written as one. A request slot posts inter-processor interrupts. A periodic tick input posts a timer interrupt to every processor at once.

The unit flags two kinds of problem with one-cycle pulses. Posting to a processor that is already pending, or clearing one that is idle, raises a warning. A command that carries no usable field raises an error. Reads of the control word also return the identifier of the processor that is reading.

Top module: `ipti_unit`

## Requirements
- R1: After reset, both pending vectors are zero, every interrupt line is low, and the warning and error pulses are low.
- R2: A write to slot 0 (control word) posts an inter-processor interrupt to processor i when bit 12+i is set. A write to slot 3 (request) does the same when bit i is set. Each line rises at the clock edge that takes the write.
- R3: In a control-word write, bit 8+i clears processor i's inter-processor bit and bit 4+i clears its timer bit. When one write both posts and clears the same processor, the clear takes effect last and the bit ends cleared.
- R4: A post to a processor whose inter-processor bit is already pending leaves that bit set and raises `warn_pulse` for one cycle.
- R5: An inter-processor clear of a processor with nothing pending, and nothing posted in the same write, changes no state and raises `warn_pulse`. Clearing an idle timer bit raises no warning.
- R6: A control-word write whose only set bit among 28, 15:4 is bit 28 changes nothing and raises no pulse. A control-word write with none of those bits set raises `err_pulse` for one cycle and changes nothing.
- R7: A `tick` cycle sets the timer bit of every processor. When a tick coincides with a timer clear, the tick wins.
- R8: Reading slot 1 returns the inter-processor vector in bits NCPU-1:0. Reading slot 2 returns the timer vector in the same bits. Writing slot 1 or slot 2 clears the bits written as one. Reading slot 3 returns zero.
- R9: A write to slot 1, 2 or 3 whose processor field (bits NCPU-1:0) is all zero raises `err_pulse` and changes nothing.
- R10: Reading slot 0 returns `rd_cpu_id` in bits 1:0, the timer vector in bits 7:4 and the inter-processor vector in bits 11:8. All other bits read as zero, and `rdata` is zero whenever `rd_en` is low.
- R11: `warn_pulse` and `err_pulse` rise only in the cycle that follows an accepted write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| reg_sel | input | 2 | Register slot select |
| wdata | input | DW | Write data |
| rd_cpu_id | input | 2 | Identifier of the processor that is reading |
| rdata | output | DW | Read data (combinational) |
| tick | input | 1 | Periodic timer tick |
| ipi_irq | output | NCPU | Inter-processor interrupt lines |
| tmr_irq | output | NCPU | Interval-timer interrupt lines |
| warn_pulse | output | 1 | Duplicate-post or idle-clear indication |
| err_pulse | output | 1 | Unsupported-command indication |

## Verification
The bench sweeps every starting inter-processor state against every post mask, and pairs each combination with a clear mask derived from both. This separates a correct set-then-clear order from one that lets the post win, and it separates warnings that come from duplicate posts from those that come from idle clears. A second sweep clears every timer pattern both through the control word and through the status slot, with and without a coinciding tick, to expose the tick-wins rule. Directed writes with zero fields and with only bit 28 set tell a real error apart from an ignored write. Reads with each processor identifier confirm the field layout.

// File: rtl/ipti_pkg.sv
package ipti_pkg;
   localparam int ID_W = 2;

   // register slot encoding
   typedef enum logic [1:0] {
      SLOT_CTRL = 2'd0,
      SLOT_IPI  = 2'd1,
      SLOT_TMR  = 2'd2,
      SLOT_REQ  = 2'd3
   } slot_e;

   // control word field positions
   localparam int POST_LSB   = 12;
   localparam int ICLR_LSB   = 8;
   localparam int TCLR_LSB   = 4;
   localparam int IGNORE_BIT = 28;
   localparam int MAX_CPU    = 4;
endpackage

// File: rtl/ipti_cmd_dec.sv
module ipti_cmd_dec
   import ipti_pkg::*;
#(
   parameter int NCPU = 4,
   parameter int DW   = 32
) (
   input  logic            wr_en,
   input  logic [1:0]      reg_sel,
   input  logic [DW-1:0]   wdata,
   output logic [NCPU-1:0] post_vec,
   output logic [NCPU-1:0] iclr_vec,
   output logic [NCPU-1:0] tclr_vec,
   output logic            bad_cmd
);
   logic [NCPU-1:0] low_field;
   logic [NCPU-1:0] f_post, f_iclr, f_tclr;
   logic            f_ign;

   assign low_field = wdata[NCPU-1:0];
   assign f_post    = wdata[POST_LSB +: NCPU];
   assign f_iclr    = wdata[ICLR_LSB +: NCPU];
   assign f_tclr    = wdata[TCLR_LSB +: NCPU];
   assign f_ign     = wdata[IGNORE_BIT];

   always_comb begin
      post_vec = '0;
      iclr_vec = '0;
      tclr_vec = '0;
      bad_cmd  = 1'b0;
      if (wr_en) begin
         unique case (slot_e'(reg_sel))
            SLOT_CTRL: begin
               post_vec = f_post;
               iclr_vec = f_iclr;
               tclr_vec = f_tclr;
               bad_cmd  = !((|f_post) || (|f_iclr) || (|f_tclr) || f_ign);
            end
            SLOT_IPI: begin
               iclr_vec = low_field;
               bad_cmd  = ~|low_field;
            end
            SLOT_TMR: begin
               tclr_vec = low_field;
               bad_cmd  = ~|low_field;
            end
            SLOT_REQ: begin
               post_vec = low_field;
               bad_cmd  = ~|low_field;
            end
            default: bad_cmd = 1'b1;
         endcase
      end
   end
endmodule

// File: rtl/ipti_pend.sv
module ipti_pend #(
   parameter int N        = 4,
   parameter bit SET_WINS = 1'b0
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [N-1:0] set_vec,
   input  logic [N-1:0] clr_vec,
   output logic [N-1:0] pend,
   output logic         dup_set,
   output logic         idle_clr
);
   logic [N-1:0] pend_q, pend_d;

   generate
      if (SET_WINS) begin : g_set_last
         assign pend_d = (pend_q & ~clr_vec) | set_vec;
      end else begin : g_clr_last
         assign pend_d = (pend_q | set_vec) & ~clr_vec;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) pend_q <= '0;
      else     pend_q <= pend_d;
   end

   assign pend     = pend_q;
   assign dup_set  = |(set_vec & pend_q);
   assign idle_clr = |(clr_vec & ~(pend_q | set_vec));
endmodule

// File: rtl/ipti_rd_mux.sv
module ipti_rd_mux
   import ipti_pkg::*;
#(
   parameter int NCPU = 4,
   parameter int DW   = 32
) (
   input  logic            rd_en,
   input  logic [1:0]      reg_sel,
   input  logic [ID_W-1:0] rd_cpu_id,
   input  logic [NCPU-1:0] ipi_pend,
   input  logic [NCPU-1:0] tmr_pend,
   output logic [DW-1:0]   rdata
);
   always_comb begin
      rdata = '0;
      if (rd_en) begin
         unique case (slot_e'(reg_sel))
            SLOT_CTRL: begin
               rdata[ID_W-1:0]           = rd_cpu_id;
               rdata[TCLR_LSB +: NCPU]   = tmr_pend;
               rdata[ICLR_LSB +: NCPU]   = ipi_pend;
            end
            SLOT_IPI: rdata[NCPU-1:0] = ipi_pend;
            SLOT_TMR: rdata[NCPU-1:0] = tmr_pend;
            default:  rdata = '0;
         endcase
      end
   end
endmodule

// File: rtl/ipti_unit.sv
module ipti_unit
   import ipti_pkg::*;
#(
   parameter int NCPU = 4,
   parameter int DW   = 32
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                wr_en,
   input  logic                rd_en,
   input  logic [1:0]          reg_sel,
   input  logic [DW-1:0]       wdata,
   input  logic [ID_W-1:0]     rd_cpu_id,
   output logic [DW-1:0]       rdata,
   input  logic                tick,
   output logic [NCPU-1:0]     ipi_irq,
   output logic [NCPU-1:0]     tmr_irq,
   output logic                warn_pulse,
   output logic                err_pulse
);
   generate
      if (NCPU < 1 || NCPU > MAX_CPU) begin : g_bad_ncpu
         $error("ipti_unit: NCPU must be 1..4");
      end
      if (DW <= IGNORE_BIT) begin : g_bad_dw
         $error("ipti_unit: DW must exceed the ignored control bit");
      end
   endgenerate

   logic [NCPU-1:0] post_vec, iclr_vec, tclr_vec;
   logic            bad_cmd;
   logic            ipi_dup, ipi_idle, tmr_dup_unused, tmr_idle_unused;
   logic            warn_q, err_q;

   ipti_cmd_dec #(.NCPU(NCPU), .DW(DW)) u_dec (
      .wr_en    (wr_en),
      .reg_sel  (reg_sel),
      .wdata    (wdata),
      .post_vec (post_vec),
      .iclr_vec (iclr_vec),
      .tclr_vec (tclr_vec),
      .bad_cmd  (bad_cmd)
   );

   ipti_pend #(.N(NCPU), .SET_WINS(1'b0)) u_ipi (
      .clk      (clk),
      .rst      (rst),
      .set_vec  (post_vec),
      .clr_vec  (iclr_vec),
      .pend     (ipi_irq),
      .dup_set  (ipi_dup),
      .idle_clr (ipi_idle)
   );

   ipti_pend #(.N(NCPU), .SET_WINS(1'b1)) u_tmr (
      .clk      (clk),
      .rst      (rst),
      .set_vec  ({NCPU{tick}}),
      .clr_vec  (tclr_vec),
      .pend     (tmr_irq),
      .dup_set  (tmr_dup_unused),
      .idle_clr (tmr_idle_unused)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         warn_q <= 1'b0;
         err_q  <= 1'b0;
      end else begin
         warn_q <= wr_en && !bad_cmd && (ipi_dup || ipi_idle);
         err_q  <= bad_cmd;
      end
   end

   assign warn_pulse = warn_q;
   assign err_pulse  = err_q;

   ipti_rd_mux #(.NCPU(NCPU), .DW(DW)) u_rd (
      .rd_en     (rd_en),
      .reg_sel   (reg_sel),
      .rd_cpu_id (rd_cpu_id),
      .ipi_pend  (ipi_irq),
      .tmr_pend  (tmr_irq),
      .rdata     (rdata)
   );
endmodule

// File: rtl/ipti_chk.sv
module ipti_chk
   import ipti_pkg::*;
#(
   parameter int NCPU = 4,
   parameter int DW   = 32
) (
   input logic                clk,
   input logic                rst,
   input logic                wr_en,
   input logic                rd_en,
   input logic [1:0]          reg_sel,
   input logic [DW-1:0]       wdata,
   input logic [ID_W-1:0]     rd_cpu_id,
   input logic [DW-1:0]       rdata,
   input logic                tick,
   input logic [NCPU-1:0]     ipi_irq,
   input logic [NCPU-1:0]     tmr_irq,
   input logic                warn_pulse,
   input logic                err_pulse
);
   logic posting;
   assign posting = wr_en && (reg_sel == SLOT_CTRL || reg_sel == SLOT_REQ);

   AST_IPI_RISE_NEEDS_POST: assert property (@(posedge clk) disable iff (rst)
      !posting |=> ((ipi_irq & ~$past(ipi_irq)) == '0)); // R2
   AST_TICK_FILLS_TMR: assert property (@(posedge clk) disable iff (rst)
      tick |=> (tmr_irq == {NCPU{1'b1}})); // R7
   AST_TMR_RISE_NEEDS_TICK: assert property (@(posedge clk) disable iff (rst)
      !tick |=> ((tmr_irq & ~$past(tmr_irq)) == '0)); // R7
   AST_FLAGS_NEED_WRITE: assert property (@(posedge clk) disable iff (rst)
      !wr_en |=> (!warn_pulse && !err_pulse)); // R11
   AST_READ_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
      !rd_en |-> (rdata == '0)); // R10
   AST_CTRL_READ_ID: assert property (@(posedge clk) disable iff (rst)
      (rd_en && reg_sel == SLOT_CTRL) |-> (rdata[ID_W-1:0] == rd_cpu_id)); // R10
endmodule

bind ipti_unit ipti_chk #(.NCPU(NCPU), .DW(DW)) u_chk (
   .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .reg_sel(reg_sel),
   .wdata(wdata), .rd_cpu_id(rd_cpu_id), .rdata(rdata), .tick(tick),
   .ipi_irq(ipi_irq), .tmr_irq(tmr_irq), .warn_pulse(warn_pulse),
   .err_pulse(err_pulse)
);

// File: tb/tb_ipti_unit.sv
module tb_ipti_unit;
   localparam int CLK_PERIOD = 10;
   localparam int NCPU = 4;
   localparam int DW   = 32;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          wr_en = 1'b0, rd_en = 1'b0, tick = 1'b0;
   logic [1:0]    reg_sel = '0;
   logic [DW-1:0] wdata = '0;
   logic [1:0]    rd_cpu_id = '0;
   logic [DW-1:0] rdata;
   logic [NCPU-1:0] ipi_irq, tmr_irq;
   logic          warn_pulse, err_pulse;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   ipti_unit #(.NCPU(NCPU), .DW(DW)) dut (
      .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .reg_sel(reg_sel),
      .wdata(wdata), .rd_cpu_id(rd_cpu_id), .rdata(rdata), .tick(tick),
      .ipi_irq(ipi_irq), .tmr_irq(tmr_irq), .warn_pulse(warn_pulse),
      .err_pulse(err_pulse)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // write takes effect at the next posedge; sample at the following negedge
   task automatic wr(input logic [1:0] sel, input logic [31:0] d, input logic tk);
      @(negedge clk);
      wr_en = 1'b1; reg_sel = sel; wdata = d; tick = tk;
      @(negedge clk);
      wr_en = 1'b0; tick = 1'b0; wdata = '0;
   endtask

   task automatic pulse_tick();
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
   endtask

   task automatic rd(input logic [1:0] sel, input logic [1:0] id, output logic [31:0] v);
      @(negedge clk);
      rd_en = 1'b1; reg_sel = sel; rd_cpu_id = id;
      #1 v = rdata;
      rd_en = 1'b0;
   endtask

   initial begin
      #(CLK_PERIOD*150000);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      // R1 reset state
      chk("R1 ipi", ipi_irq, 0);
      chk("R1 tmr", tmr_irq, 0);
      chk("R1 flags", {warn_pulse, err_pulse}, 0);

      // R2 R3 R4 R5: sweep start state x post mask
      for (int s = 0; s < 16; s++) begin
         for (int r = 0; r < 16; r++) begin
            int c;
            int exp_st;
            bit exp_w, exp_e;
            c = (s * 3 + r * 5) & 4'hF;
            if (((s + r) % 3) == 0) c = 0;
            wr(2'd1, 32'hF, 1'b0);
            if (s != 0) wr(2'd3, s, 1'b0);
            chk("R2 setup", ipi_irq, s);
            wr(2'd0, (r << 12) | (c << 8), 1'b0);
            exp_e  = (r == 0) && (c == 0);
            exp_st = exp_e ? s : ((s | r) & ~c & 4'hF);
            exp_w  = !exp_e && (((s & r) != 0) || ((c & ~(s | r) & 4'hF) != 0));
            chk("R3 ipi state after post/clear", ipi_irq, exp_st);
            chk("R4 R5 warn", warn_pulse, exp_w);
            chk("R6 err on empty ctrl", err_pulse, exp_e);
         end
      end

      // R6 ignored bit only
      wr(2'd1, 32'hF, 1'b0);
      wr(2'd3, 32'h5, 1'b0);
      wr(2'd0, 32'h1000_0000, 1'b0);
      chk("R6 ignored ipi", ipi_irq, 4'h5);
      chk("R6 ignored flags", {warn_pulse, err_pulse}, 0);

      // R7 R3 R8: timer clears through ctrl word and status slot
      for (int c = 0; c < 16; c++) begin
         for (int path = 0; path < 2; path++) begin
            pulse_tick();
            chk("R7 tick fills", tmr_irq, 4'hF);
            if (c == 0) continue;
            if (path == 0) wr(2'd0, c << 4, 1'b0);
            else           wr(2'd2, c, 1'b0);
            chk(path == 0 ? "R3 tmr ctrl clear" : "R8 tmr slot clear", tmr_irq, ~c & 4'hF);
            chk("R5 tmr no warn", warn_pulse, 1'b0);
            rd(2'd2, 2'd0, v);
            chk("R8 tmr read", v, ~c & 4'hF);
            wr(2'd2, c, 1'b1);
            chk("R7 tick beats clear", tmr_irq, 4'hF);
         end
      end

      // R9 zero fields
      for (int sl = 1; sl < 4; sl++) begin
         wr(sl[1:0], 32'hF0, 1'b0);
         chk("R9 err", err_pulse, 1'b1);
         chk("R9 ipi unchanged", ipi_irq, 4'h5);
         chk("R9 tmr unchanged", tmr_irq, 4'hF);
      end

      // R8 R10 reads
      wr(2'd2, 32'h6, 1'b0);
      rd(2'd1, 2'd0, v); chk("R8 ipi read", v, 32'h5);
      rd(2'd3, 2'd0, v); chk("R8 req read", v, 32'h0);
      for (int id = 0; id < 4; id++) begin
         rd(2'd0, id[1:0], v);
         chk("R10 ctrl read", v, (32'h5 << 8) | (32'h9 << 4) | id);
      end
      @(negedge clk); #1 chk("R10 idle read", rdata, 0);
      chk("R11 quiet", {warn_pulse, err_pulse}, 0);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule